// File: doc/BRIEF.md
# Dual gated timer/counter

This block holds two independent 16-bit count channels. Each channel is a pair of byte registers, a low byte and a high byte. One shared mode byte and one shared control byte govern both channels. A channel advances either on a prescaled internal tick or on falling edges seen on its own count pin.

Counting can be permitted by a software run bit alone. It can also be permitted by the run bit together with an external gate pin. When a channel rolls over, its overflow flag in the control byte is set, and that flag is presented as an interrupt request.

Software reaches all six byte registers through a small address/data write port and a combinational read port. Four count layouts are selectable per channel:
- a 13-bit counter;
- a 16-bit counter;
- an 8-bit counter that reloads itself from the high byte;
- a split layout, in which channel 0 becomes two 8-bit counters and channel 1 freezes.

Top module: `tmr_pair`

## Requirements
- R1: While reset is asserted, and after it is released, all six registers read 0x00 and both `ovf_irq` bits are 0.
- R2: Register addresses are: 0 control, 1 mode, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high. Every bit written reads back unchanged while nothing counts. The mode byte changes only when it is written. In the mode byte, bits 7..4 configure channel 1 and bits 3..0 configure channel 0, each nibble laid out as {gate, source, mode[1:0]}.
- R3: With source = 0, an enabled channel advances exactly once per PRESCALE (default 12) clock cycles.
- R4: With source = 1, the count pin is sampled once per PRESCALE cycles. The channel advances once for each sample of 1 that is followed by a sample of 0.
- R5: A channel is enabled only when its run bit is 1 and either its gate bit is 0 or its gate pin is 1. The run bits are control bit 4 for channel 0 and control bit 6 for channel 1. A disabled channel holds its value.
- R6: Mode 00 is a 13-bit counter formed by the high byte and bits 4..0 of the low byte. Bits 7..5 of the low byte never change by counting. Overflow occurs at high=0xFF with low[4:0]=0x1F.
- R7: Mode 01 is a 16-bit counter {high, low}. It overflows from 0xFFFF to 0x0000.
- R8: Mode 10 counts the low byte only. On overflow the low byte is loaded from the high byte, and the high byte is unchanged.
- R9: Mode 11 on channel 0 splits it. The low byte is an 8-bit counter under channel 0's controls and sets the channel 0 flag. The high byte is an 8-bit internal-tick counter run by control bit 6, and it sets the channel 1 flag. Mode 11 on channel 1 freezes channel 1.
- R10: An overflow sets the channel's flag: control bit 5 for channel 0 and bit 7 for channel 1. The flags drive `ovf_irq[0]` and `ovf_irq[1]`. A flag stays set until software writes it to 0. A hardware set in the same cycle as a clearing write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cnt_in | input | 2 | External count pins, bit i for channel i |
| gate_in | input | 2 | External gate pins, bit i for channel i |
| ovf_irq | output | 2 | Overflow interrupt requests (control flags) |

## Verification
Some behaviours are checked by assertions on every cycle:
- tick spacing;
- a disabled channel holding its value;
- the untouched upper low-byte bits in the 13-bit layout;
- the reload in the 8-bit layout;
- flag persistence, and a flag being set after an overflow;
- a mode byte that changes only on a write.

Other behaviours only the bench scenarios show. These are the exact count reached after a known number of ticks or pin pulses, the gate pin's effect, the split layout's two halves, and end values in each mode under randomized preloads and run lengths. For those, the bench computes the results step by step with its own model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    TM_13B   = 2'b00,
    TM_16B   = 2'b01,
    TM_8RL   = 2'b10,
    TM_SPLIT = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      src_pin;
    tmr_mode_e mode;
  } tmr_cfg_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_LO0  = 3'd2;
  localparam logic [2:0] A_HI0  = 3'd3;
  localparam logic [2:0] A_LO1  = 3'd4;
  localparam logic [2:0] A_HI1  = 3'd5;

  localparam int CB_FLAG1 = 7;
  localparam int CB_RUN1  = 6;
  localparam int CB_FLAG0 = 5;
  localparam int CB_RUN0  = 4;

endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
  parameter int PRESCALE = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_n = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  generate
    if (PRESCALE > 1) begin : g_gap_chk
      AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
    end
  endgenerate

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int BW     = 8,
  parameter int M0_LOW = 5,
  parameter bit SPLIT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cnt_pin,
  input  logic          gate_pin,
  input  logic          run,
  input  logic          hi_run,
  input  tmr_cfg_t      cfg,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi,
  output logic          ovf,
  output logic          hi_ovf
);
  logic [BW-1:0] lo_n, hi_n;
  logic          pin_q;
  logic          pin_fall, en, evt, split;

  always_comb begin
    pin_fall = tick & pin_q & ~cnt_pin;
    en       = run & (~cfg.gate | gate_pin);
    evt      = en & (cfg.src_pin ? pin_fall : tick);
    split    = SPLIT && (cfg.mode == TM_SPLIT);
    lo_n     = lo;
    hi_n     = hi;
    ovf      = 1'b0;
    hi_ovf   = 1'b0;
    unique case (cfg.mode)
      TM_13B: if (evt) begin
        if (&lo[M0_LOW-1:0]) begin
          lo_n = {lo[BW-1:M0_LOW], {M0_LOW{1'b0}}};
          hi_n = hi + BW'(1);
          ovf  = &hi;
        end else begin
          lo_n = lo + BW'(1);
        end
      end
      TM_16B: if (evt) begin
        {hi_n, lo_n} = {hi, lo} + (2*BW)'(1);
        ovf          = &{hi, lo};
      end
      TM_8RL: if (evt) begin
        if (&lo) begin
          lo_n = hi;
          ovf  = 1'b1;
        end else begin
          lo_n = lo + BW'(1);
        end
      end
      default: if (split) begin
        if (evt) begin
          lo_n = lo + BW'(1);
          ovf  = &lo;
        end
        if (tick && hi_run) begin
          hi_n   = hi + BW'(1);
          hi_ovf = &hi;
        end
      end
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_q <= 1'b0;
    else if (tick) pin_q <= cnt_pin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_lo && !wr_hi && cfg.mode != TM_SPLIT) |=> ($stable(lo) && $stable(hi))); // R5
  AST_M0_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == TM_13B && !wr_lo) |=> (lo[BW-1:M0_LOW] == $past(lo[BW-1:M0_LOW]))); // R6
  AST_M2_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == TM_8RL && ovf && !wr_lo) |=> (lo == $past(hi))); // R8

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 12,
  parameter int NCH      = 2,
  parameter int BW       = 8,
  parameter int M0_LOW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [1:0]    cnt_in,
  input  logic [1:0]    gate_in,
  output logic [1:0]    ovf_irq
);
  localparam int CFGW = $bits(tmr_cfg_t);

  logic [1:0] rst_sync_q;
  logic       rst_ok;
  logic       tick;
  logic [7:0] ctrl_q, ctrl_n, mode_q, mode_n;
  logic       wr_ctrl, wr_mode, set0, set1;

  logic [BW-1:0] lo_v [NCH];
  logic [BW-1:0] hi_v [NCH];
  logic [NCH-1:0] ovf_v, hiovf_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  tmr_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk  (clk),
    .rst_n(rst_ok),
    .tick (tick)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      localparam logic [2:0] ALO = 3'(2 + 2*i);
      localparam logic [2:0] AHI = 3'(3 + 2*i);
      tmr_chan #(.BW(BW), .M0_LOW(M0_LOW), .SPLIT(i == 0)) u_chan (
        .clk     (clk),
        .rst_n   (rst_ok),
        .tick    (tick),
        .cnt_pin (cnt_in[i]),
        .gate_pin(gate_in[i]),
        .run     (ctrl_q[CB_RUN0 + 2*i]),
        .hi_run  ((i == 0) ? ctrl_q[CB_RUN1] : 1'b0),
        .cfg     (tmr_cfg_t'(mode_q[CFGW*i +: CFGW])),
        .wr_lo   (reg_wr && reg_addr == ALO),
        .wr_hi   (reg_wr && reg_addr == AHI),
        .wdata   (reg_wdata),
        .lo      (lo_v[i]),
        .hi      (hi_v[i]),
        .ovf     (ovf_v[i]),
        .hi_ovf  (hiovf_v[i])
      );
    end
  endgenerate

  always_comb begin
    wr_ctrl = reg_wr && reg_addr == A_CTRL;
    wr_mode = reg_wr && reg_addr == A_MODE;
    set0    = ovf_v[0];
    set1    = ovf_v[1] | (|hiovf_v);
    ctrl_n  = wr_ctrl ? reg_wdata : ctrl_q;
    if (set0) ctrl_n[CB_FLAG0] = 1'b1;
    if (set1) ctrl_n[CB_FLAG1] = 1'b1;
    mode_n  = wr_mode ? reg_wdata : mode_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      mode_q <= mode_n;
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_MODE:  reg_rdata = mode_q;
      A_LO0:   reg_rdata = lo_v[0];
      A_HI0:   reg_rdata = hi_v[0];
      A_LO1:   reg_rdata = lo_v[1];
      A_HI1:   reg_rdata = hi_v[1];
      default: reg_rdata = 8'h00;
    endcase
  end

  assign ovf_irq = {ctrl_q[CB_FLAG1], ctrl_q[CB_FLAG0]};

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_mode |=> $stable(mode_q)); // R2
  AST_FLAG0_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    ovf_v[0] |=> ovf_irq[0]); // R10
  AST_FLAG1_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    (ovf_v[1] || hiovf_v[0]) |=> ovf_irq[1]); // R10
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_ok)
    (ovf_irq[0] && !wr_ctrl) |=> ovf_irq[0]); // R10

endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  localparam int PRE = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [1:0] cnt_in = 2'b00;
  logic [1:0] gate_in = 2'b00;
  logic [1:0] ovf_irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_in(cnt_in),
    .gate_in(gate_in), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // clear run bits, keep flags and other bits (read-modify-write in one cycle)
  task automatic stop_runs();
    @(negedge clk);
    reg_addr = 3'd0;
    #0.5;
    reg_wdata = reg_rdata & 8'hAF;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // run bits set for exactly 12*ticks clock edges -> exactly `ticks` ticks
  task automatic run_ticks(input logic [7:0] runs, input int ticks);
    wr(3'd0, runs);
    repeat (PRE*ticks - 2) @(negedge clk);
    stop_runs();
  endtask

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic o;
    o = 1'b0;
    case (m)
      2'b00: if (lo[4:0] == 5'h1F) begin
        lo = {lo[7:5], 5'd0}; o = (hi == 8'hFF); hi = hi + 8'd1;
      end else lo = lo + 8'd1;
      2'b01: begin o = ({hi, lo} == 16'hFFFF); {hi, lo} = {hi, lo} + 16'd1; end
      2'b10: if (lo == 8'hFF) begin lo = hi; o = 1'b1; end else lo = lo + 8'd1;
      default: ;
    endcase
    return {o, hi, lo};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reset in", {8'h0, d}, 16'h0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 after reset", {8'h0, d}, 16'h0);
    end
    chk("R1 irq", {14'h0, ovf_irq}, 16'h0);

    // R2 readback
    wr(3'd1, 8'hAA); rd(3'd1, d); chk("R2 mode readback", {8'h0, d}, 16'h00AA);
    wr(3'd2, 8'h12); wr(3'd3, 8'h34); wr(3'd4, 8'h56); wr(3'd5, 8'h78);
    rd(3'd2, d); chk("R2 lo0", {8'h0, d}, 16'h12);
    rd(3'd3, d); chk("R2 hi0", {8'h0, d}, 16'h34);
    rd(3'd4, d); chk("R2 lo1", {8'h0, d}, 16'h56);
    rd(3'd5, d); chk("R2 hi1", {8'h0, d}, 16'h78);
    wr(3'd0, 8'hAF); rd(3'd0, d); chk("R2 ctrl readback", {8'h0, d}, 16'h00AF);
    chk("R10 irq from flags", {14'h0, ovf_irq}, 16'h3);
    wr(3'd0, 8'h00); chk("R10 irq cleared", {14'h0, ovf_irq}, 16'h0);

    // R3 internal tick, channel 0 mode 01
    wr(3'd1, 8'h01); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    run_ticks(8'h10, 7);
    rd(3'd2, d); chk("R3 seven ticks", {8'h0, d}, 16'h7);
    repeat (40) @(negedge clk);
    rd(3'd2, d); chk("R5 stopped holds", {8'h0, d}, 16'h7);

    // R7 16-bit rollover and R10 flag
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
    run_ticks(8'h10, 3);
    rd(3'd2, d); rd(3'd3, d2); chk("R7 wrap", {d2, d}, 16'h0001);
    chk("R10 flag0 set", {14'h0, ovf_irq}, 16'h1);
    repeat (30) @(negedge clk);
    chk("R10 flag0 sticky", {14'h0, ovf_irq}, 16'h1);
    wr(3'd0, 8'h00); chk("R10 flag0 cleared by write", {14'h0, ovf_irq}, 16'h0);

    // R6 13-bit
    wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h00);
    run_ticks(8'h10, 2);
    rd(3'd2, d); rd(3'd3, d2); chk("R6 13-bit wrap keeps lo[7:5]", {d2, d}, 16'h00E0);
    chk("R6 flag0", {14'h0, ovf_irq}, 16'h1);
    wr(3'd0, 8'h00);

    // R8 reload
    wr(3'd1, 8'h02); wr(3'd2, 8'hFE); wr(3'd3, 8'h80);
    run_ticks(8'h10, 4);
    rd(3'd2, d); rd(3'd3, d2); chk("R8 reload", {d2, d}, 16'h8082);
    wr(3'd0, 8'h00);

    // R4 counter source on channel 0 (mode nibble 0101)
    wr(3'd1, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h10);
    for (int p = 0; p < 5; p++) begin
      cnt_in[0] = 1'b1; repeat (2*PRE) @(negedge clk);
      cnt_in[0] = 1'b0; repeat (2*PRE) @(negedge clk);
    end
    cnt_in[0] = 1'b1; repeat (4*PRE) @(negedge clk);
    stop_runs();
    rd(3'd2, d); chk("R4 five falling edges", {8'h0, d}, 16'h5);
    cnt_in[0] = 1'b0;

    // R5 gate on channel 1 (nibble 1001)
    wr(3'd1, 8'h90); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    gate_in[1] = 1'b0;
    run_ticks(8'h40, 5);
    rd(3'd4, d); chk("R5 gate pin low blocks", {8'h0, d}, 16'h0);
    gate_in[1] = 1'b1;
    run_ticks(8'h40, 5);
    rd(3'd4, d); chk("R5 gate pin high counts", {8'h0, d}, 16'h5);
    wr(3'd1, 8'h10); gate_in[1] = 1'b0;
    run_ticks(8'h40, 3);
    rd(3'd4, d); chk("R5 gate off ignores pin", {8'h0, d}, 16'h8);

    // R9 split
    wr(3'd1, 8'h33); wr(3'd2, 8'hFE); wr(3'd3, 8'hFD); wr(3'd4, 8'h10); wr(3'd5, 8'h20);
    wr(3'd0, 8'h00);
    run_ticks(8'h50, 3);
    rd(3'd2, d); chk("R9 split low", {8'h0, d}, 16'h01);
    rd(3'd3, d); chk("R9 split high", {8'h0, d}, 16'h00);
    rd(3'd4, d); rd(3'd5, d2); chk("R9 channel 1 frozen", {d2, d}, 16'h2010);
    chk("R9 both flags", {14'h0, ovf_irq}, 16'h3);
    wr(3'd0, 8'h00);

    // randomized preload/length in modes 00..10
    for (int it = 0; it < 24; it++) begin
      logic ch; logic [1:0] m; logic [7:0] lo, hi; logic [16:0] r; logic fl; int n;
      ch = 1'($urandom % 2);
      m  = 2'($urandom % 3);
      lo = 8'($urandom); hi = ($urandom % 2) ? 8'hFF : 8'($urandom);
      n  = 1 + int'($urandom % 40);
      wr(3'd1, ch ? {2'b00, m, 4'h0} : {6'h0, m});
      wr(ch ? 3'd4 : 3'd2, lo); wr(ch ? 3'd5 : 3'd3, hi);
      wr(3'd0, 8'h00);
      fl = 1'b0; r = {1'b0, hi, lo};
      for (int k = 0; k < n; k++) begin
        r = step(m, r[7:0], r[15:8]);
        fl |= r[16];
      end
      run_ticks(ch ? 8'h40 : 8'h10, n);
      rd(ch ? 3'd4 : 3'd2, d); rd(ch ? 3'd5 : 3'd3, d2);
      case (m)
        2'b00: chk("R6 random", {d2, d}, r[15:0]);
        2'b01: chk("R7 random", {d2, d}, r[15:0]);
        default: chk("R8 random", {d2, d}, r[15:0]);
      endcase
      chk("R10 random flag", {15'h0, ovf_irq[ch]}, {15'h0, fl});
      wr(3'd0, 8'h00);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule